// File: doc/BRIEF.md
# Fully Associative Tagged Translation Buffer

This block holds a small set of address translations and searches all of them at once. Each slot remembers an aligned virtual page, a page size, a partition number, a context number, a flag that marks the mapping as real rather than virtual, and an opaque 64-bit payload. Two payload bits mean something to the block. Bit 6 is a lock bit. Bits [1:0] are a size code c that gives a page of 2^(13+3c) bytes.

The block has two request ports, and both can be used in the same cycle. The lookup port takes a translation query and, one cycle later, returns a hit flag, the slot index and the payload. The operation port takes one maintenance command per cycle: insert, demap page, demap context, demap partition, read tag or read payload. A lookup that shares a cycle with a state-changing command is answered from the contents the table had before that cycle. Victims for automatic inserts come from a scan of per-slot used bits that passes over locked slots.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is invalid. `lu_done` and `rd_done` are low, every lookup misses, and every tag read returns all ones.
- R2: `lu_done` rises in the cycle after `lu_req`. A slot hits only if it is valid, has the same partition and the same real flag, the query address lies in its page, and, for a non-real slot, the context is the same. The lowest hitting index is returned with its payload. A miss returns `lu_hit`=0, index 0 and a payload of 0.
- R3: An insert first invalidates every valid slot that has the same real flag and partition, whose page overlaps the new page, and for which either the new mapping is real or the slot has the same context. No two slots can then hit the same lookup.
- R4: The victim of an insert is chosen in this order: `op_idx` when `op_idx_en` is set and the index is below ENTRIES, then the lowest invalid slot, then the lowest slot whose used bit and lock bit are both clear, and finally slot ENTRIES-1.
- R5: An insert makes its slot valid and used. If every slot is then used, every used bit is cleared except the new slot's.
- R6: A lookup hit with `lu_probe`=0 sets that slot's used bit and applies the same clear rule as R5. A probe lookup, or a lookup in a cycle that carries a state-changing command, leaves the used bits unchanged.
- R7: Demap page (`op_kind`=1) invalidates the slot that the same query would hit as a lookup.
- R8: Demap context (`op_kind`=2) invalidates every slot whose partition and context match, whatever its real flag.
- R9: Demap partition (`op_kind`=3) invalidates every unlocked slot of the partition. Locked slots stay.
- R10: A tag read (`op_kind`=4) returns a word with the context in [12:0], page address bits in [55:13], zeros in [59:58], the inverted size code in [57:56], the real flag in [60] and the partition in [63:61]. `rd_done` is high in the following cycle.
- R11: A payload read (`op_kind`=5) returns the stored payload. A read of an invalid slot, or of an index at or above ENTRIES, returns all ones. Kinds 6 and 7 do nothing.
- R12: Insert is `op_kind`=0. Every command completes in one cycle. A lookup issued in the same cycle as an insert or a demap reports the contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_req | input | 1 | Lookup request |
| lu_va | input | VA_W | Lookup virtual address |
| lu_part | input | 3 | Lookup partition |
| lu_ctx | input | 13 | Lookup context |
| lu_real | input | 1 | Lookup wants a real mapping |
| lu_probe | input | 1 | Lookup is a probe and does not mark the slot used |
| lu_done | output | 1 | Lookup result valid |
| lu_hit | output | 1 | Lookup found a slot |
| lu_idx | output | IDX_W | Index of the hitting slot |
| lu_data | output | 64 | Payload of the hitting slot |
| op_req | input | 1 | Command request |
| op_kind | input | 3 | Command: 0 insert, 1 demap page, 2 demap context, 3 demap partition, 4 tag read, 5 payload read |
| op_va | input | VA_W | Command address |
| op_part | input | 3 | Command partition |
| op_ctx | input | 13 | Command context |
| op_real | input | 1 | Command real flag |
| op_idx_en | input | 1 | Insert uses `op_idx` as its slot |
| op_idx | input | IDX_W | Slot index for an insert or a read |
| op_data | input | 64 | Insert payload |
| rd_done | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |

## Verification
The bench builds the table with ENTRIES=8 and VA_W=48. With eight slots, a few inserts fill the table, so the used-bit wrap, the scan past locked slots and the case where every slot is locked all come up in directed sequences. Random traffic uses a small pool of pages, partitions and contexts, so overlapping inserts and multi-slot demaps happen often. Every result is compared with a reference table kept in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int CTX_W      = 13;
  localparam int PART_W     = 3;
  localparam int SZ_W       = 2;
  localparam int DATA_W     = 64;
  localparam int VA_MAX     = 56;
  localparam int LOCK_POS   = 6;
  localparam int BASE_SHIFT = 13;

  typedef enum logic [2:0] {
    OP_INSERT   = 3'd0,
    OP_DMAP_PG  = 3'd1,
    OP_DMAP_CTX = 3'd2,
    OP_DMAP_ALL = 3'd3,
    OP_RD_TAG   = 3'd4,
    OP_RD_DATA  = 3'd5
  } tlb_op_e;

  // byte-offset mask of a page with size code c: 2^(13+3c)-1
  function automatic logic [VA_MAX-1:0] page_mask(input logic [SZ_W-1:0] code);
    page_mask = (VA_MAX'(1) << (BASE_SHIFT + 3 * int'(code))) - VA_MAX'(1);
  endfunction

  function automatic logic [63:0] tag_word(input logic [VA_MAX-1:BASE_SHIFT] vpage,
                                           input logic [PART_W-1:0] part,
                                           input logic [CTX_W-1:0] ctx,
                                           input logic rl,
                                           input logic [SZ_W-1:0] code);
    tag_word = {part, rl, 2'b00, ~code, vpage, ctx};
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 48,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][VA_W-1:0]   ent_va,
  input  logic [ENTRIES-1:0][VA_W-1:0]   ent_mask,
  input  logic [ENTRIES-1:0][PART_W-1:0] ent_part,
  input  logic [ENTRIES-1:0][CTX_W-1:0]  ent_ctx,
  input  logic [ENTRIES-1:0]             ent_real,
  input  logic [ENTRIES-1:0]             ent_lock,
  input  logic [VA_W-1:0]                lq_va,
  input  logic [PART_W-1:0]              lq_part,
  input  logic [CTX_W-1:0]               lq_ctx,
  input  logic                           lq_real,
  input  logic [VA_W-1:0]                oq_va,
  input  logic [VA_W-1:0]                oq_mask,
  input  logic [PART_W-1:0]              oq_part,
  input  logic [CTX_W-1:0]               oq_ctx,
  input  logic                           oq_real,
  output logic [ENTRIES-1:0]             lu_vec,
  output logic                           lu_any,
  output logic [IDX_W-1:0]               lu_first,
  output logic [ENTRIES-1:0]             pg_vec,
  output logic [ENTRIES-1:0]             ovl_vec,
  output logic [ENTRIES-1:0]             ctx_vec,
  output logic [ENTRIES-1:0]             part_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic l_same, o_same;
    assign l_same = ent_valid[i] && ent_part[i] == lq_part && ent_real[i] == lq_real;
    assign o_same = ent_valid[i] && ent_part[i] == oq_part && ent_real[i] == oq_real;
    assign lu_vec[i]  = l_same && ((ent_va[i] ^ lq_va) & ~ent_mask[i]) == '0
                        && (ent_real[i] || ent_ctx[i] == lq_ctx);
    assign pg_vec[i]  = o_same && ((ent_va[i] ^ oq_va) & ~ent_mask[i]) == '0
                        && (ent_real[i] || ent_ctx[i] == oq_ctx);
    assign ovl_vec[i] = o_same && ((ent_va[i] ^ oq_va) & ~(ent_mask[i] | oq_mask)) == '0
                        && (oq_real || ent_ctx[i] == oq_ctx);
    assign ctx_vec[i] = ent_valid[i] && ent_part[i] == oq_part && ent_ctx[i] == oq_ctx;
    assign part_vec[i] = ent_valid[i] && ent_part[i] == oq_part && !ent_lock[i];
  end

  always_comb begin
    lu_any   = |lu_vec;
    lu_first = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lu_vec[i]) lu_first = IDX_W'(i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] free_vec,
  input  logic [ENTRIES-1:0] pick_vec,
  input  logic               pin_en,
  input  logic [IDX_W-1:0]   pin_idx,
  output logic [IDX_W-1:0]   vic_idx
);
  logic [IDX_W-1:0] first_free, first_pick;
  logic             have_free, have_pick;

  always_comb begin
    first_free = '0;
    first_pick = '0;
    have_free  = 1'b0;
    have_pick  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) begin first_free = IDX_W'(i); have_free = 1'b1; end
      if (pick_vec[i]) begin first_pick = IDX_W'(i); have_pick = 1'b1; end
    end
    if (pin_en)         vic_idx = pin_idx;
    else if (have_free) vic_idx = first_free;
    else if (have_pick) vic_idx = first_pick;
    else                vic_idx = IDX_W'(ENTRIES - 1);
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 48,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lu_req,
  input  logic [VA_W-1:0]   lu_va,
  input  logic [PART_W-1:0] lu_part,
  input  logic [CTX_W-1:0]  lu_ctx,
  input  logic              lu_real,
  input  logic              lu_probe,
  output logic              lu_done,
  output logic              lu_hit,
  output logic [IDX_W-1:0]  lu_idx,
  output logic [DATA_W-1:0] lu_data,
  input  logic              op_req,
  input  logic [2:0]        op_kind,
  input  logic [VA_W-1:0]   op_va,
  input  logic [PART_W-1:0] op_part,
  input  logic [CTX_W-1:0]  op_ctx,
  input  logic              op_real,
  input  logic              op_idx_en,
  input  logic [IDX_W-1:0]  op_idx,
  input  logic [DATA_W-1:0] op_data,
  output logic              rd_done,
  output logic [63:0]       rd_data
);
  initial assert (ENTRIES >= 2 && ENTRIES <= 64 && VA_W > BASE_SHIFT && VA_W <= VA_MAX);

  logic [ENTRIES-1:0]              valid_q, used_q, real_q;
  logic [ENTRIES-1:0][VA_W-1:0]    va_q;
  logic [ENTRIES-1:0][PART_W-1:0]  part_q;
  logic [ENTRIES-1:0][CTX_W-1:0]   ctx_q;
  logic [ENTRIES-1:0][DATA_W-1:0]  data_q;
  logic [ENTRIES-1:0][VA_W-1:0]    mask_w;
  logic [ENTRIES-1:0]              lock_w;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_field
    assign lock_w[i] = data_q[i][LOCK_POS];
    assign mask_w[i] = VA_W'(page_mask(data_q[i][SZ_W-1:0]));
  end

  // decoded command events
  logic ins_fire, dpg_fire, dctx_fire, dall_fire, mut_fire, rtag_fire, rdat_fire;
  assign ins_fire  = op_req && op_kind == OP_INSERT;
  assign dpg_fire  = op_req && op_kind == OP_DMAP_PG;
  assign dctx_fire = op_req && op_kind == OP_DMAP_CTX;
  assign dall_fire = op_req && op_kind == OP_DMAP_ALL;
  assign rtag_fire = op_req && op_kind == OP_RD_TAG;
  assign rdat_fire = op_req && op_kind == OP_RD_DATA;
  assign mut_fire  = ins_fire || dpg_fire || dctx_fire || dall_fire;

  logic [VA_W-1:0] new_mask, new_va;
  assign new_mask = VA_W'(page_mask(op_data[SZ_W-1:0]));
  assign new_va   = op_va & ~new_mask;

  logic [ENTRIES-1:0] lu_vec, pg_vec, ovl_vec, ctx_vec, part_vec;
  logic               lu_any;
  logic [IDX_W-1:0]   lu_first;

  tlb_cam #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_cam (
    .ent_valid(valid_q), .ent_va(va_q), .ent_mask(mask_w), .ent_part(part_q),
    .ent_ctx(ctx_q), .ent_real(real_q), .ent_lock(lock_w),
    .lq_va(lu_va), .lq_part(lu_part), .lq_ctx(lu_ctx), .lq_real(lu_real),
    .oq_va(op_va), .oq_mask(new_mask), .oq_part(op_part), .oq_ctx(op_ctx),
    .oq_real(op_real),
    .lu_vec(lu_vec), .lu_any(lu_any), .lu_first(lu_first), .pg_vec(pg_vec),
    .ovl_vec(ovl_vec), .ctx_vec(ctx_vec), .part_vec(part_vec)
  );

  logic               pin_ok;
  logic [IDX_W-1:0]   vic_idx;
  logic [ENTRIES-1:0] free_vec, pick_vec;
  assign pin_ok   = op_idx_en && (int'(op_idx) < ENTRIES);
  assign free_vec = ~(valid_q & ~ovl_vec);
  assign pick_vec = ~used_q & ~lock_w;

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .free_vec(free_vec), .pick_vec(pick_vec), .pin_en(pin_ok),
    .pin_idx(op_idx), .vic_idx(vic_idx)
  );

  // next valid / used state
  logic [ENTRIES-1:0] kill_vec, valid_n, used_n, vic_oh, hit_oh;
  logic               touch, used_wrap;
  assign vic_oh = ENTRIES'(1) << vic_idx;
  assign hit_oh = ENTRIES'(1) << lu_first;
  assign touch  = lu_req && !lu_probe && lu_any && !mut_fire;

  always_comb begin
    kill_vec = '0;
    if (ins_fire)  kill_vec = ovl_vec;
    if (dpg_fire)  kill_vec = pg_vec;
    if (dctx_fire) kill_vec = ctx_vec;
    if (dall_fire) kill_vec = part_vec;
    valid_n   = valid_q & ~kill_vec;
    used_n    = used_q & ~kill_vec;
    used_wrap = 1'b0;
    if (ins_fire) begin
      valid_n = valid_n | vic_oh;
      used_n  = used_n | vic_oh;
      if (&used_n) begin used_n = vic_oh; used_wrap = 1'b1; end
    end else if (touch) begin
      used_n = used_n | hit_oh;
      if (&used_n) begin used_n = hit_oh; used_wrap = 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
    end else begin
      valid_q <= valid_n;
      used_q  <= used_n;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      va_q[vic_idx]   <= new_va;
      part_q[vic_idx] <= op_part;
      ctx_q[vic_idx]  <= op_ctx;
      real_q[vic_idx] <= op_real;
      data_q[vic_idx] <= op_data;
    end
  end

  // diagnostic read path
  logic                       rd_ok;
  logic [VA_MAX-1:BASE_SHIFT] rd_vpage;
  logic [63:0]                rd_word;
  assign rd_ok    = (int'(op_idx) < ENTRIES) && valid_q[op_idx];
  assign rd_vpage = (VA_MAX - BASE_SHIFT)'(va_q[op_idx] >> BASE_SHIFT);
  assign rd_word  = rtag_fire ? tag_word(rd_vpage, part_q[op_idx], ctx_q[op_idx],
                                         real_q[op_idx], data_q[op_idx][SZ_W-1:0])
                              : data_q[op_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lu_done <= 1'b0;
      lu_hit  <= 1'b0;
      lu_idx  <= '0;
      lu_data <= '0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      lu_done <= lu_req;
      lu_hit  <= lu_req && lu_any;
      lu_idx  <= (lu_req && lu_any) ? lu_first : '0;
      lu_data <= (lu_req && lu_any) ? data_q[lu_first] : '0;
      rd_done <= rtag_fire || rdat_fire;
      if (rtag_fire || rdat_fire) rd_data <= rd_ok ? rd_word : '1;
    end
  end

  // ---------------- assertions ----------------
  p_lookup_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lu_req |=> lu_done);

  p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lu_vec));

  p_insert_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> valid_q[$past(vic_idx)] && used_q[$past(vic_idx)]);

  p_used_only_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q & ~valid_q) == '0);

  p_never_all_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(&used_q));

  p_probe_keeps_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_req && lu_probe && !mut_fire) |=> used_q == $past(used_q));

  p_locked_survive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dall_fire |=> ($past(valid_q & lock_w) & ~valid_q) == '0);
endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
  localparam int CLK_NS = 10;
  localparam int N      = 8;
  localparam int IW     = 3;
  localparam int VW     = 48;
  localparam logic [2:0] K_INS = 3'd0, K_DPG = 3'd1, K_DCTX = 3'd2,
                         K_DALL = 3'd3, K_RTAG = 3'd4, K_RDAT = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic            lu_req = 0, lu_real = 0, lu_probe = 0;
  logic [VW-1:0]   lu_va = '0;
  logic [2:0]      lu_part = '0;
  logic [12:0]     lu_ctx = '0;
  logic            lu_done, lu_hit;
  logic [IW-1:0]   lu_idx;
  logic [63:0]     lu_data;
  logic            op_req = 0, op_real = 0, op_idx_en = 0;
  logic [2:0]      op_kind = '0, op_part = '0;
  logic [VW-1:0]   op_va = '0;
  logic [12:0]     op_ctx = '0;
  logic [IW-1:0]   op_idx = '0;
  logic [63:0]     op_data = '0;
  logic            rd_done;
  logic [63:0]     rd_data;

  tlb_fa #(.ENTRIES(N), .VA_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lu_req(lu_req), .lu_va(lu_va), .lu_part(lu_part), .lu_ctx(lu_ctx),
    .lu_real(lu_real), .lu_probe(lu_probe),
    .lu_done(lu_done), .lu_hit(lu_hit), .lu_idx(lu_idx), .lu_data(lu_data),
    .op_req(op_req), .op_kind(op_kind), .op_va(op_va), .op_part(op_part),
    .op_ctx(op_ctx), .op_real(op_real), .op_idx_en(op_idx_en), .op_idx(op_idx),
    .op_data(op_data), .rd_done(rd_done), .rd_data(rd_data)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference table
  bit          m_valid[N], m_used[N], m_real[N];
  logic [63:0] m_va[N], m_data[N];
  int          m_part[N], m_ctx[N];

  // stimulus fields
  bit          s_lreq, s_probe, s_lreal, s_oreq, s_oreal, s_ien;
  logic [63:0] s_lva, s_ova, s_odata;
  int          s_lpart, s_lctx, s_opart, s_octx, s_oidx;
  logic [2:0]  s_kind;

  function automatic logic [63:0] b_mask(input logic [63:0] d);
    int sh;
    sh = 13 + 3 * int'(d[1:0]);
    return (64'd1 << sh) - 64'd1;
  endfunction

  function automatic int m_find(input logic [63:0] va, input int part, input int ctx, input bit rl);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_part[i] == part && m_real[i] == rl &&
          ((m_va[i] ^ va) & ~b_mask(m_data[i])) == 64'd0 && (rl || m_ctx[i] == ctx))
        return i;
    return -1;
  endfunction

  function automatic logic [63:0] m_tag(input int i);
    logic [63:0] t;
    if (!m_valid[i]) return '1;
    t = 64'(m_ctx[i]) | (m_va[i] & ~64'h1fff);
    t = t | (64'(m_part[i]) << 61) | (64'(m_real[i]) << 60);
    t = t | (64'(~m_data[i][1:0] & 2'b11) << 56);
    return t;
  endfunction

  function automatic bit all_used();
    for (int i = 0; i < N; i++) if (!m_used[i]) return 0;
    return 1;
  endfunction

  task automatic kill(input int i);
    m_valid[i] = 0;
    m_used[i]  = 0;
  endtask

  task automatic m_insert();
    logic [63:0] msk, nva;
    int v;
    msk = b_mask(s_odata);
    nva = s_ova & ~msk;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_real[i] == s_oreal && m_part[i] == s_opart &&
          ((m_va[i] ^ nva) & ~(b_mask(m_data[i]) | msk)) == 64'd0 &&
          (s_oreal || m_ctx[i] == s_octx))
        kill(i);
    v = -1;
    if (s_ien && s_oidx < N) v = s_oidx;
    for (int i = 0; i < N && v < 0; i++) if (!m_valid[i]) v = i;
    for (int i = 0; i < N && v < 0; i++) if (!m_used[i] && !m_data[i][6]) v = i;
    if (v < 0) v = N - 1;
    m_va[v] = nva; m_part[v] = s_opart; m_ctx[v] = s_octx;
    m_real[v] = s_oreal; m_data[v] = s_odata;
    m_valid[v] = 1; m_used[v] = 1;
    if (all_used()) begin
      for (int i = 0; i < N; i++) m_used[i] = 0;
      m_used[v] = 1;
    end
  endtask

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin bad++; $display("FAIL %s", msg); end
  endtask

  // one cycle: drive the staged stimulus, check results, update the table
  task automatic step(input string tag);
    int ex;
    logic [63:0] exp_rd;
    bit is_rd, mut;
    ex = s_lreq ? m_find(s_lva, s_lpart, s_lctx, s_lreal) : -1;
    is_rd = s_oreq && (s_kind == K_RTAG || s_kind == K_RDAT);
    mut = s_oreq && s_kind <= K_DALL;
    exp_rd = '1;
    if (is_rd && s_oidx < N && m_valid[s_oidx])
      exp_rd = (s_kind == K_RTAG) ? m_tag(s_oidx) : m_data[s_oidx];
    lu_req = s_lreq; lu_va = s_lva[VW-1:0]; lu_part = 3'(s_lpart);
    lu_ctx = 13'(s_lctx); lu_real = s_lreal; lu_probe = s_probe;
    op_req = s_oreq; op_kind = s_kind; op_va = s_ova[VW-1:0];
    op_part = 3'(s_opart); op_ctx = 13'(s_octx); op_real = s_oreal;
    op_idx_en = s_ien; op_idx = IW'(s_oidx); op_data = s_odata;
    @(negedge clk);
    if (s_lreq) begin
      if (ex < 0)
        chk(lu_done && !lu_hit && lu_data == 64'd0,
            $sformatf("%s lookup: actual done=%0b hit=%0b data=%h expected miss", tag, lu_done, lu_hit, lu_data));
      else
        chk(lu_done && lu_hit && lu_idx == IW'(ex) && lu_data == m_data[ex],
            $sformatf("%s lookup: actual hit=%0b idx=%0d data=%h expected idx=%0d data=%h",
                      tag, lu_hit, lu_idx, lu_data, ex, m_data[ex]));
    end
    if (is_rd)
      chk(rd_done && rd_data == exp_rd,
          $sformatf("%s read: actual done=%0b data=%h expected %h", tag, rd_done, rd_data, exp_rd));
    if (mut) begin
      case (s_kind)
        K_INS: m_insert();
        K_DPG: begin
          int p;
          p = m_find(s_ova, s_opart, s_octx, s_oreal);
          if (p >= 0) kill(p);
        end
        K_DCTX: for (int i = 0; i < N; i++)
                  if (m_valid[i] && m_part[i] == s_opart && m_ctx[i] == s_octx) kill(i);
        default: for (int i = 0; i < N; i++)
                  if (m_valid[i] && m_part[i] == s_opart && !m_data[i][6]) kill(i);
      endcase
    end else if (s_lreq && !s_probe && ex >= 0) begin
      m_used[ex] = 1;
      if (all_used()) begin
        for (int i = 0; i < N; i++) m_used[i] = 0;
        m_used[ex] = 1;
      end
    end
    lu_req = 0; op_req = 0;
    s_lreq = 0; s_oreq = 0;
  endtask

  task automatic set_lu(input logic [63:0] va, input int part, input int ctx, input bit rl, input bit probe);
    s_lreq = 1; s_lva = va; s_lpart = part; s_lctx = ctx; s_lreal = rl; s_probe = probe;
  endtask

  task automatic set_op(input logic [2:0] kind, input logic [63:0] va, input int part, input int ctx,
                        input bit rl, input bit ien, input int idx, input logic [63:0] data);
    s_oreq = 1; s_kind = kind; s_ova = va; s_opart = part; s_octx = ctx;
    s_oreal = rl; s_ien = ien; s_oidx = idx; s_odata = data;
  endtask

  task automatic look(input logic [63:0] va, input int part, input int ctx, input bit rl,
                      input bit probe, input string tag);
    set_lu(va, part, ctx, rl, probe);
    step(tag);
  endtask

  task automatic ins(input logic [63:0] va, input int part, input int ctx, input bit rl,
                     input logic [63:0] data, input bit ien, input int idx, input string tag);
    set_op(K_INS, va, part, ctx, rl, ien, idx, data);
    step(tag);
  endtask

  task automatic sweep(input logic [2:0] kind, input string tag);
    for (int i = 0; i < N; i++) begin
      set_op(kind, 64'd0, 0, 0, 0, 0, i, 64'd0);
      step(tag);
    end
  endtask

  initial begin
    #(CLK_NS * 40000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    s_lreq = 0; s_oreq = 0;
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_used[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!lu_done && !rd_done && !lu_hit,
        $sformatf("R1 reset outputs: actual done=%0b rd=%0b hit=%0b expected 0", lu_done, rd_done, lu_hit));
    sweep(K_RTAG, "R1");
    look(64'h0, 0, 1, 0, 0, "R1");

    // R4: fill free slots in order
    for (int k = 0; k < N; k++) ins(64'(k) << 13, 0, 1, 0, 64'(k) << 8, 0, 0, "R4");
    for (int k = 0; k < N; k++) look((64'(k) << 13) | 64'h5a, 0, 1, 0, 1, "R4");
    // R5: the last fill wrapped the used bits, so slot 0 goes next
    ins(64'h10000, 0, 1, 0, 64'h1100, 0, 0, "R5");
    look(64'h10010, 0, 1, 0, 1, "R5");
    look(64'h0, 0, 1, 0, 1, "R5");
    // R6: a real hit marks slot 1 used, so slot 2 is replaced next
    look(64'h2004, 0, 1, 0, 0, "R6");
    ins(64'h12000, 0, 1, 0, 64'h1200, 0, 0, "R6");
    look(64'h12000, 0, 1, 0, 1, "R6");
    // R6: a probe does not protect slot 3
    look(64'h6000, 0, 1, 0, 1, "R6");
    ins(64'h14000, 0, 1, 0, 64'h1400, 0, 0, "R6");
    look(64'h14000, 0, 1, 0, 1, "R6");
    // R12 + R7: lookup alongside a demap of the same page sees the old entry
    set_lu(64'h14100, 0, 1, 0, 0);
    set_op(K_DPG, 64'h14000, 0, 1, 0, 0, 0, 64'd0);
    step("R12");
    look(64'h14100, 0, 1, 0, 1, "R7");
    // R3: a large page removes the small ones of the same context only
    ins(64'h4000, 0, 2, 0, 64'h2200, 0, 0, "R3");
    ins(64'h0, 0, 1, 0, 64'h3301, 0, 0, "R3");
    look(64'h6008, 0, 1, 0, 1, "R3");
    look(64'h4008, 0, 2, 0, 1, "R3");
    sweep(K_RTAG, "R10");
    sweep(K_RDAT, "R11");
    // R8: demap context 2
    set_op(K_DCTX, 64'd0, 0, 2, 0, 0, 0, 64'd0);
    step("R8");
    look(64'h4008, 0, 2, 0, 1, "R8");
    // R9: demap partition 1 spares the locked slot
    ins(64'h40000, 1, 0, 0, 64'h5540, 0, 0, "R9");
    ins(64'h42000, 1, 0, 0, 64'h5500, 0, 0, "R9");
    set_op(K_DALL, 64'd0, 1, 0, 0, 0, 0, 64'd0);
    step("R9");
    look(64'h40000, 1, 0, 0, 1, "R9");
    look(64'h42000, 1, 0, 0, 1, "R9");
    // R4: pinned locked inserts everywhere, then an automatic one lands last
    for (int k = 0; k < N; k++) ins(64'h100000 + (64'(k) << 13), 0, 3, 0, 64'h40 | (64'(k) << 12), 1, k, "R4");
    ins(64'h200000, 0, 3, 0, 64'h7700, 0, 0, "R4");
    look(64'h200000, 0, 3, 0, 1, "R4");
    // R2: a real mapping ignores the context
    ins(64'h80000, 0, 5, 1, 64'h8840, 1, 2, "R2");
    look(64'h81234, 0, 9, 1, 1, "R2");
    look(64'h81234, 0, 5, 0, 1, "R2");
    // R11: reading a slot that was demapped returns all ones
    set_op(K_DPG, 64'h80000, 0, 0, 1, 0, 0, 64'd0);
    step("R7");
    set_op(K_RDAT, 64'd0, 0, 0, 0, 0, 2, 64'd0);
    step("R11");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [63:0] d;
      r = $urandom % 10;
      d = {$urandom, $urandom};
      d[1:0] = ($urandom % 8 == 0) ? 2'd2 : (($urandom % 4 == 0) ? 2'd1 : 2'd0);
      d[6] = ($urandom % 8 == 0);
      if ($urandom % 2 == 0)
        set_lu((64'($urandom % 24) << 13) | 64'($urandom % 8192), $urandom % 2,
               $urandom % 3, ($urandom % 4 == 0), ($urandom % 2 == 0));
      if (r < 8)
        set_op((r < 3) ? K_INS : ((r < 6) ? 3'(r - 2) : 3'(r - 2)),
               (64'($urandom % 24) << 13) | 64'($urandom % 8192), $urandom % 2, $urandom % 3,
               ($urandom % 4 == 0), ($urandom % 5 == 0), $urandom % N, d);
      step("R2");
    end
    sweep(K_RTAG, "R10");
    sweep(K_RDAT, "R11");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule